// File: doc/BRIEF.md
# Time-base and watchdog generator

This block turns a 32768 Hz source clock into two timing services that share one divide-by-256 prescaler. The first is a time-base square wave whose frequency is picked by a 3-bit code, from 1 Hz up to 128 Hz. The second is a watchdog whose time-out period is four times the selected time-base period. When the watchdog times out, it latches a sticky flag.

Either service can pull an open-drain interrupt pin low. The pin is modelled as a drive-enable output plus the level that an external pull-up would produce. A serial front end decodes host commands into one-cycle strobes, and those strobes drive this block. Each strobe acts on the clock edge where it is high. The release of `rst_n` must be synchronous to `clk`.

The three enables (timer, watchdog, interrupt) are independent. The prescaler never stops or restarts, so changing the select code takes effect at once.

Top module: `tbw_gen`

## Requirements
- R1: After reset the timer, watchdog and interrupt are all disabled, the select code is 000, `irq_oe` is 0 and `irq_level` is 1.
- R2: With the interrupt and timer enabled, `irq_oe` is high exactly while the time-base wave is low. With the default divider, code c (000 slowest to 111 fastest) gives 2^c Hz. The wave is bit (PRE_BITS-1+7-c) of the concatenation {post-prescaler counter, prescaler counter}. The prescaler counter advances once per clock, and the post-prescaler counter advances when the prescaler wraps from all ones.
- R3: A clear-timer strobe zeroes the post-prescaler counter on its edge and leaves the prescaler running.
- R4: A watchdog enable or clear-watchdog strobe restarts the watchdog count. The flag then sets on the 2^(9-c)-th prescaler wrap strictly after that edge. With the default divider this is 4 s at code 000 and 1/32 s at code 111.
- R5: A set watchdog flag holds `irq_oe` high while the interrupt and watchdog are enabled. It stays set until a clear-watchdog or interrupt-disable strobe, which clears it on that edge.
- R6: While the interrupt is disabled, `irq_oe` is 0 and `irq_level` is 1, whatever the timer and watchdog state.
- R7: Each enable is set by its enable strobe and cleared by its disable strobe, and disable wins when both arrive together. Changing the timer enable does not disturb the watchdog flag.
- R8: A select-code load takes effect on its edge without restarting the prescaler or the post-prescaler counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock (32768 Hz in the target use) |
| rst_n | input | 1 | Asynchronous active-low reset, synchronous release |
| cmd_tmr_en | input | 1 | Strobe: enable the time-base output |
| cmd_tmr_dis | input | 1 | Strobe: disable the time-base output |
| cmd_wdt_en | input | 1 | Strobe: enable the watchdog |
| cmd_wdt_dis | input | 1 | Strobe: disable the watchdog |
| cmd_irq_en | input | 1 | Strobe: enable the interrupt pin |
| cmd_irq_dis | input | 1 | Strobe: release the interrupt pin and clear the watchdog flag |
| cmd_clr_tmr | input | 1 | Strobe: zero the post-prescaler time-base counter |
| cmd_clr_wdt | input | 1 | Strobe: restart the watchdog count and clear its flag |
| cmd_sel_load | input | 1 | Strobe: load `sel_code` |
| sel_code | input | SEL_W | Frequency select code |
| irq_oe | output | 1 | Open-drain drive enable (1 pulls the pin low) |
| irq_level | output | 1 | Pin level seen with an external pull-up |

## Verification
Every output comes combinationally from registers that update on the edge where a strobe is high. The bench therefore samples at the falling edge that follows that rising edge and expects the new state there, with no further delay. Wave expectations are computed from a count of rising edges since reset and the edge of the last timer clear. The watchdog time-out edge is computed from the restart edge as the first edge divisible by four after it, plus four edges per remaining wrap. The output is checked low on the edge before that one and high on the edge itself. A reduced prescaler width keeps the slowest codes within reach, so every select code is swept over at least two wave periods.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

  typedef struct packed {
    logic tmr_en;
    logic tmr_dis;
    logic wdt_en;
    logic wdt_dis;
    logic irq_en;
    logic irq_dis;
    logic clr_tmr;
    logic clr_wdt;
    logic sel_load;
  } tbw_cmd_t;

  // Set/clear flag update: the clearing strobe has priority.
  function automatic logic flag_next(input logic cur, input logic set_s, input logic clr_s);
    logic r;
    if (clr_s)      r = 1'b0;
    else if (set_s) r = 1'b1;
    else            r = cur;
    return r;
  endfunction

endpackage

// File: rtl/tbw_prescaler.sv
module tbw_prescaler #(
  parameter int PRE_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [PRE_BITS-1:0] cnt,
  output logic                tick
);

  logic [PRE_BITS-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt + 1'b1;
  end

  // Wrap indication: the next edge carries into the following stages.
  assign tick = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/tbw_timebase.sv
module tbw_timebase #(
  parameter int PRE_BITS = 8,
  parameter int SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                clr,
  input  logic [PRE_BITS-1:0] pre_cnt,
  input  logic [SEL_W-1:0]    sel,
  output logic                wave
);

  localparam int TB_BITS = (1 << SEL_W) - 1;
  localparam int FULL_W  = PRE_BITS + TB_BITS;

  logic [TB_BITS-1:0] tb_cnt;
  logic [TB_BITS-1:0] tb_nxt;
  logic [FULL_W-1:0]  chain;
  logic [FULL_W-1:0]  aligned;

  always_comb begin
    if (clr)       tb_nxt = '0;
    else if (tick) tb_nxt = tb_cnt + 1'b1;
    else           tb_nxt = tb_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_cnt <= '0;
    else        tb_cnt <= tb_nxt;
  end

  // Code 0 picks the chain's top bit, the highest code picks the prescaler MSB.
  always_comb begin
    chain   = {tb_cnt, pre_cnt};
    aligned = chain << sel;
    wave    = aligned[FULL_W-1];
  end

endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
  parameter int SEL_W     = 3,
  parameter int WDT_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             clr,
  input  logic             irq_dis,
  input  logic [SEL_W-1:0] sel,
  output logic             flag
);

  import tbw_pkg::*;

  localparam int TB_BITS = (1 << SEL_W) - 1;
  localparam int WD_W    = TB_BITS + WDT_EXTRA;

  logic [WD_W-1:0] wd_cnt;
  logic [WD_W-1:0] wd_nxt;
  logic [WD_W-1:0] mask;
  logic            hit;
  logic            flag_nxt_v;

  always_comb begin
    mask = {WD_W{1'b1}} >> sel;
    hit  = en && tick && ((wd_cnt & mask) == mask);
  end

  always_comb begin
    if (!en || clr)  wd_nxt = '0;
    else if (hit)    wd_nxt = '0;
    else if (tick)   wd_nxt = wd_cnt + 1'b1;
    else             wd_nxt = wd_cnt;
    flag_nxt_v = flag_next(flag, hit, clr || irq_dis);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt <= '0;
      flag   <= 1'b0;
    end else begin
      wd_cnt <= wd_nxt;
      flag   <= flag_nxt_v;
    end
  end

endmodule

// File: rtl/tbw_gen.sv
module tbw_gen #(
  parameter int PRE_BITS  = 8,
  parameter int SEL_W     = 3,
  parameter int WDT_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_tmr_en,
  input  logic             cmd_tmr_dis,
  input  logic             cmd_wdt_en,
  input  logic             cmd_wdt_dis,
  input  logic             cmd_irq_en,
  input  logic             cmd_irq_dis,
  input  logic             cmd_clr_tmr,
  input  logic             cmd_clr_wdt,
  input  logic             cmd_sel_load,
  input  logic [SEL_W-1:0] sel_code,
  output logic             irq_level,
  output logic             irq_oe
);

  import tbw_pkg::*;

  tbw_cmd_t            cmd;
  logic                tmr_en_q, wdt_en_q, irq_en_q;
  logic                tmr_en_d, wdt_en_d, irq_en_d;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic [PRE_BITS-1:0] pre_cnt;
  logic                tick;
  logic                wave;
  logic                wdt_flag;

  always_comb begin
    cmd.tmr_en   = cmd_tmr_en;
    cmd.tmr_dis  = cmd_tmr_dis;
    cmd.wdt_en   = cmd_wdt_en;
    cmd.wdt_dis  = cmd_wdt_dis;
    cmd.irq_en   = cmd_irq_en;
    cmd.irq_dis  = cmd_irq_dis;
    cmd.clr_tmr  = cmd_clr_tmr;
    cmd.clr_wdt  = cmd_clr_wdt;
    cmd.sel_load = cmd_sel_load;
  end

  always_comb begin
    tmr_en_d = flag_next(tmr_en_q, cmd.tmr_en, cmd.tmr_dis);
    wdt_en_d = flag_next(wdt_en_q, cmd.wdt_en, cmd.wdt_dis);
    irq_en_d = flag_next(irq_en_q, cmd.irq_en, cmd.irq_dis);
    sel_d    = cmd.sel_load ? sel_code : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_en_q <= 1'b0;
      wdt_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      tmr_en_q <= tmr_en_d;
      wdt_en_q <= wdt_en_d;
      irq_en_q <= irq_en_d;
      sel_q    <= sel_d;
    end
  end

  tbw_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (pre_cnt),
    .tick  (tick)
  );

  tbw_timebase #(.PRE_BITS(PRE_BITS), .SEL_W(SEL_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .clr     (cmd.clr_tmr),
    .pre_cnt (pre_cnt),
    .sel     (sel_q),
    .wave    (wave)
  );

  tbw_watchdog #(.SEL_W(SEL_W), .WDT_EXTRA(WDT_EXTRA)) u_wdt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (wdt_en_q),
    .clr     (cmd.clr_wdt),
    .irq_dis (cmd.irq_dis),
    .sel     (sel_q),
    .flag    (wdt_flag)
  );

  always_comb begin
    irq_oe    = irq_en_q && ((tmr_en_q && !wave) || (wdt_en_q && wdt_flag));
    irq_level = !irq_oe;
  end

endmodule

// File: rtl/tbw_gen_chk.sv
module tbw_gen_chk #(
  parameter int PRE_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_irq_dis,
  input logic                cmd_clr_wdt,
  input logic                irq_oe,
  input logic                wdt_flag,
  input logic                tick,
  input logic [PRE_BITS-1:0] pre_cnt
);

  assert_irq_dis_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_irq_dis |=> !irq_oe);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_flag && !cmd_clr_wdt && !cmd_irq_dis) |=> wdt_flag);

  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_wdt || cmd_irq_dis) |=> !wdt_flag);

  assert_timeout_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_flag) |-> $past(tick));

  // Prescaler is never restarted by clears or select loads (R3, R8).
  assert_prescaler_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pre_cnt == PRE_BITS'($past(pre_cnt) + 1'b1)));

endmodule

bind tbw_gen tbw_gen_chk #(.PRE_BITS(PRE_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_irq_dis (cmd_irq_dis),
  .cmd_clr_wdt (cmd_clr_wdt),
  .irq_oe      (irq_oe),
  .wdt_flag    (wdt_flag),
  .tick        (tick),
  .pre_cnt     (pre_cnt)
);

// File: tb/tbw_gen_tb.sv
module tbw_gen_tb;

  localparam int B_TMR_EN  = 0;
  localparam int B_TMR_DIS = 1;
  localparam int B_WDT_EN  = 2;
  localparam int B_WDT_DIS = 3;
  localparam int B_IRQ_EN  = 4;
  localparam int B_IRQ_DIS = 5;
  localparam int B_CLR_TMR = 6;
  localparam int B_CLR_WDT = 7;
  localparam int B_SEL     = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] cmd = '0;
  logic [2:0] sel = '0;
  logic       irq_level, irq_oe;

  int n = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int last_edge = 0;
  int m_clr = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) n <= 0;
    else        n <= n + 1;
  end

  tbw_gen #(.PRE_BITS(2), .SEL_W(3), .WDT_EXTRA(2)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_tmr_en   (cmd[B_TMR_EN]),
    .cmd_tmr_dis  (cmd[B_TMR_DIS]),
    .cmd_wdt_en   (cmd[B_WDT_EN]),
    .cmd_wdt_dis  (cmd[B_WDT_DIS]),
    .cmd_irq_en   (cmd[B_IRQ_EN]),
    .cmd_irq_dis  (cmd[B_IRQ_DIS]),
    .cmd_clr_tmr  (cmd[B_CLR_TMR]),
    .cmd_clr_wdt  (cmd[B_CLR_WDT]),
    .cmd_sel_load (cmd[B_SEL]),
    .sel_code     (sel),
    .irq_level    (irq_level),
    .irq_oe       (irq_oe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge=%0d actual=%0b expected=%0b", req, n, act, exp);
    end
  endtask

  // Pulse strobes for one clock; returns at the falling edge after the applying edge.
  task automatic issue(input logic [8:0] v, input logic [2:0] s);
    @(negedge clk);
    cmd = v;
    sel = s;
    last_edge = n + 1;
    @(negedge clk);
    cmd = '0;
  endtask

  // Time-base wave after edge nn with the last timer clear at edge mm (PRE_BITS=2).
  function automatic logic exp_wave(input int nn, input int mm, input int c);
    int f;
    f = ((((nn >> 2) - (mm >> 2)) & 127) << 2) | (nn & 3);
    return f[8 - c];
  endfunction

  function automatic int timeout_edge(input int start, input int c);
    return ((start >> 2) + 1) * 4 + 4 * ((1 << (9 - c)) - 1);
  endfunction

  task automatic sweep_wave(input int cycles, input int c, input string req);
    for (int i = 0; i < cycles; i++) begin
      chk(req, irq_oe, !exp_wave(n, m_clr, c));
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int t;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 oe", irq_oe, 1'b0);
    chk("R1 level", irq_level, 1'b1);
    repeat (10) @(negedge clk);
    chk("R1 still released", irq_oe, 1'b0);

    // R2, R3: every code, starting each sweep with a timer clear at an arbitrary phase
    issue(9'(1 << B_IRQ_EN) | 9'(1 << B_TMR_EN), 3'd0);
    m_clr = 0;
    sweep_wave(40, 0, "R2 code0 from reset");
    for (int c = 0; c < 8; c++) begin
      issue(9'(1 << B_SEL) | 9'(1 << B_CLR_TMR), 3'(c));
      m_clr = last_edge;
      sweep_wave(2 * (1 << (9 - c)) + 7 + c, c, "R2,R3 sweep");
    end

    // R8: select change without clear keeps counting
    issue(9'(1 << B_SEL), 3'd3);
    sweep_wave(300, 3, "R8 sel 3");
    issue(9'(1 << B_SEL), 3'd6);
    sweep_wave(100, 6, "R8 sel 6");
    // R3: clear with the fastest code leaves the prescaler phase intact
    issue(9'(1 << B_SEL), 3'd7);
    sweep_wave(9, 7, "R8 sel 7");
    issue(9'(1 << B_CLR_TMR), 3'd7);
    m_clr = last_edge;
    sweep_wave(20, 7, "R3 clear at code7");

    // R7: enable and disable together -> disabled
    issue(9'(1 << B_TMR_EN) | 9'(1 << B_TMR_DIS), 3'd7);
    for (int i = 0; i < 20; i++) begin
      chk("R7 disable wins", irq_oe, 1'b0);
      @(negedge clk);
    end

    // R4: watchdog time-out at code 7
    issue(9'(1 << B_WDT_EN), 3'd7);
    t = timeout_edge(last_edge, 7);
    while (n < t) begin
      chk("R4 before timeout c7", irq_oe, 1'b0);
      @(negedge clk);
    end
    chk("R4 timeout c7", irq_oe, 1'b1);

    // R5: sticky
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R5 sticky", irq_oe, 1'b1);
    end
    // R7: timer enable changes leave the flag alone
    issue(9'(1 << B_TMR_EN), 3'd7);
    chk("R7 tmr on flag kept", irq_oe, 1'b1);
    issue(9'(1 << B_TMR_DIS), 3'd7);
    chk("R7 tmr off flag kept", irq_oe, 1'b1);

    // R5/R4: clear watchdog restarts the count at code 5
    issue(9'(1 << B_CLR_WDT) | 9'(1 << B_SEL), 3'd5);
    w = last_edge;
    chk("R5 cleared by clr", irq_oe, 1'b0);
    t = timeout_edge(w, 5);
    while (n < t) begin
      chk("R4 before timeout c5", irq_oe, 1'b0);
      @(negedge clk);
    end
    chk("R4 timeout c5", irq_oe, 1'b1);
    repeat (5) @(negedge clk);
    chk("R5 sticky c5", irq_oe, 1'b1);

    // R6: interrupt disable releases and stays released through later time-outs
    issue(9'(1 << B_IRQ_DIS), 3'd5);
    for (int i = 0; i < 150; i++) begin
      chk("R6 released oe", irq_oe, 1'b0);
      chk("R6 released level", irq_level, 1'b1);
      @(negedge clk);
    end
    issue(9'(1 << B_TMR_EN), 3'd7);
    for (int i = 0; i < 12; i++) begin
      chk("R6 timer ignored", irq_oe, 1'b0);
      @(negedge clk);
    end

    done = 1'b1;
    finish_run();
  end

endmodule